// File: doc/BRIEF.md
# Power-Management Event and Control Register Block

This block holds the event status, the control bits and a free-running timer for system power management. Software reaches it through a small register bus. It supplies three views: a status word, a control word and the live timer count. Two events set status bits. The first is a falling edge on a chosen bit of the timer, which marks a timer overflow. The second is a release pulse from firmware, which sets the global status bit. Software clears either bit by writing a one to it.

An interrupt request is raised from the status bits. The timer overflow contributes only when both its own enable input and the interrupt enable bit in the control word are set. The global status bit raises the request on its own, whatever the enable bits hold. The control word also carries a scratch bit and a 3-bit sleep type. It has two trigger bits that read back as zero. One sends a one-cycle release event toward firmware. The other issues a one-cycle sleep request that carries the sleep type, unless that type is a reserved code.

Top module: `pm1_evt_regs`

## Requirements
- R1: After the platform reset and the RTC-well reset, the status word (offset 0x0), the control word (offset 0x4) and the timer (offset 0x8) read zero, and sci_req, fw_event and sleep_req are low.
- R2: The timer adds one in each cycle where tick_en is high, wraps from its all-ones value to zero, and reads zero-extended at offset 0x8.
- R3: Status bit 0 (timer overflow) becomes 1 on the clock edge where timer bit OVF_BIT goes from 1 to 0.
- R4: A write to offset 0x0 clears status bit 0 and status bit 5 where the written data bit is 1, and leaves them unchanged where it is 0.
- R5: When a set event and a write-one-to-clear reach the same status bit in one cycle, the bit ends up set.
- R6: A high fw_release input sets status bit 5 (global status), and while that bit is set sci_req is high even when the interrupt enable is 0.
- R7: sci_req equals (status bit 0 AND tmr_ovf_en AND control bit 0) OR status bit 5.
- R8: The control word holds the interrupt enable at bit 0, a scratch bit at bit 1 and the sleep type at bits 12:10. Every other control bit reads 0. Status bits other than 0 and 5 read 0, and a read at any other offset returns 0.
- R9: Control bit 2 always reads 0. Writing a 1 to it makes fw_event high for exactly the one cycle after the write.
- R10: Control bit 13 always reads 0. Writing a 1 to it makes sleep_req high for the one cycle after the write, and sleep_type shows the type field written in that same access (000 S0, 001 S1, 101 S3, 110 S4, 111 S5).
- R11: A sleep request whose type is 010, 011 or 100 produces no sleep_req pulse.
- R12: The sleep type field keeps its value through the platform reset (rst_n) and is cleared only by the RTC-well reset (rtc_rst_n).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Platform reset, synchronous, active low |
| rtc_rst_n | input | 1 | RTC-well reset for the sleep type, synchronous, active low |
| tick_en | input | 1 | Timer advance enable (one pulse per timer tick) |
| tmr_ovf_en | input | 1 | Timer overflow enable from the enable register |
| fw_release | input | 1 | Firmware release pulse that sets the global status bit |
| addr | input | 4 | Register byte offset |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 32 | Write data |
| rd_en | input | 1 | Read strobe |
| rd_data | output | 32 | Read data, combinational, zero when rd_en is low |
| sci_req | output | 1 | System-control interrupt request |
| fw_event | output | 1 | One-cycle release event toward firmware |
| sleep_req | output | 1 | One-cycle sleep request |
| sleep_type | output | 3 | Sleep type carried with the last accepted request |

## Verification
The assertions check five rules on every cycle. The timer steps by one on each tick. A set event beats a clear in the same cycle. A clear with no competing set takes effect. A pulse never carries a reserved sleep type. The global status bit always forces the interrupt request. Other behaviour shows up only in the bench scenarios, because each one needs a particular sequence of stimulus. These are the overflow edge after an exact number of ticks, the exact-cycle race between a set and a clear, the silent drop of reserved sleep types, and the sleep type surviving a platform reset.

// File: rtl/pm1_pkg.sv
// Shared offsets, bit positions and sleep-type helpers for the power-management
// event register block. Assumes byte offsets on a 4-bit address.
package pm1_pkg;
    localparam int ADDR_W = 4;
    localparam logic [ADDR_W-1:0] OFS_STATUS  = 4'h0;
    localparam logic [ADDR_W-1:0] OFS_CONTROL = 4'h4;
    localparam logic [ADDR_W-1:0] OFS_TIMER   = 4'h8;

    // status bit positions
    localparam int ST_TMROF = 0;
    localparam int ST_GBL   = 5;
    // control bit positions
    localparam int CT_SCI   = 0;
    localparam int CT_SCR   = 1;
    localparam int CT_REL   = 2;
    localparam int CT_TYPLO = 10;
    localparam int CT_SLEEP = 13;

    typedef enum logic [2:0] {
        SLP_S0 = 3'b000,
        SLP_S1 = 3'b001,
        SLP_S3 = 3'b101,
        SLP_S4 = 3'b110,
        SLP_S5 = 3'b111
    } slp_type_e;

    // True when the 3-bit sleep code is one of the defined states
    function automatic logic slp_type_ok(input logic [2:0] t);
        return !(t == 3'b010 || t == 3'b011 || t == 3'b100);
    endfunction
endpackage

// File: rtl/pm_timer.sv
// Free-running power-management timer. Advances on tick_en and wraps at all-ones.
// Flags ovf_pulse in the cycle whose tick drives bit OVF_BIT from 1 to 0.
// Assumes OVF_BIT < TMR_W and a synchronous active-low reset.
module pm_timer #(
    parameter int TMR_W   = 24,
    parameter int OVF_BIT = 22
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_en,
    output logic [TMR_W-1:0] count,
    output logic             ovf_pulse
);
    logic [TMR_W-1:0] count_nx;

    // Next count value and falling-edge detection on the watched bit
    always_comb begin
        count_nx  = count + 1'b1;
        ovf_pulse = tick_en && count[OVF_BIT] && !count_nx[OVF_BIT];
    end

    // Counter register
    always_ff @(posedge clk) begin
        if (!rst_n)       count <= '0;
        else if (tick_en) count <= count_nx;
    end

    // R2
    timer_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick_en |=> count == TMR_W'($past(count) + 1'b1));
endmodule

// File: rtl/pm_status.sv
// Two sticky status bits: timer overflow and global status. Each is set by its
// event and cleared by a write of one. A set in the same cycle wins over a clear.
module pm_status (
    input  logic clk,
    input  logic rst_n,
    input  logic ovf_set,
    input  logic gbl_set,
    input  logic clr_wr,
    input  logic clr_tmrof,
    input  logic clr_gbl,
    output logic tmrof,
    output logic gbl
);
    // Sticky bits with set priority
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tmrof <= 1'b0;
            gbl   <= 1'b0;
        end else begin
            tmrof <= ovf_set || (tmrof && !(clr_wr && clr_tmrof));
            gbl   <= gbl_set || (gbl && !(clr_wr && clr_gbl));
        end
    end

    // R5
    tmrof_set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_set |=> tmrof);
    // R4
    tmrof_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_wr && clr_tmrof && !ovf_set) |=> !tmrof);
endmodule

// File: rtl/pm_control.sv
// Control word: interrupt enable, scratch bit, sleep type, and two write-only
// triggers (firmware release event and sleep request). The sleep type sits in
// the RTC well and is cleared only by rtc_rst_n. A sleep request uses the type
// written in the same access and is dropped when that type is reserved.
module pm_control
    import pm1_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rtc_rst_n,
    input  logic       ctl_wr,
    input  logic       wd_sci,
    input  logic       wd_scr,
    input  logic       wd_rel,
    input  logic       wd_sleep,
    input  logic [2:0] wd_typ,
    output logic       sci_en,
    output logic       scratch,
    output logic [2:0] slp_typ,
    output logic       fw_event,
    output logic       sleep_req,
    output logic [2:0] sleep_type
);
    // Sleep type field, RTC-well reset only
    always_ff @(posedge clk) begin
        if (!rtc_rst_n)  slp_typ <= 3'b000;
        else if (ctl_wr) slp_typ <= wd_typ;
    end

    // Platform-reset control bits and one-cycle trigger pulses
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sci_en     <= 1'b0;
            scratch    <= 1'b0;
            fw_event   <= 1'b0;
            sleep_req  <= 1'b0;
            sleep_type <= SLP_S0;
        end else begin
            fw_event  <= ctl_wr && wd_rel;
            sleep_req <= ctl_wr && wd_sleep && slp_type_ok(wd_typ);
            if (ctl_wr) begin
                sci_en  <= wd_sci;
                scratch <= wd_scr;
                if (wd_sleep && slp_type_ok(wd_typ)) sleep_type <= wd_typ;
            end
        end
    end

    // R11
    sleep_type_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sleep_req |-> slp_type_ok(sleep_type));
endmodule

// File: rtl/pm1_evt_regs.sv
// Top of the power-management event register block. Decodes the register bus,
// muxes read data combinationally, and forms the interrupt request.
// Assumes TMR_W < 32 and single-cycle read/write strobes.
module pm1_evt_regs
    import pm1_pkg::*;
#(
    parameter int TMR_W   = 24,
    parameter int OVF_BIT = 22
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rtc_rst_n,
    input  logic              tick_en,
    input  logic              tmr_ovf_en,
    input  logic              fw_release,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic [31:0]       wr_data,
    input  logic              rd_en,
    output logic [31:0]       rd_data,
    output logic              sci_req,
    output logic              fw_event,
    output logic              sleep_req,
    output logic [2:0]        sleep_type
);
    localparam int PAD_W = 32 - TMR_W;

    logic [TMR_W-1:0] tmr_count;
    logic             tmr_ovf;
    logic             st_tmrof, st_gbl;
    logic             c_sci, c_scr;
    logic [2:0]       c_typ;
    logic             wr_status, wr_control;
    logic             unused_wd_bits;

    // Write decode
    always_comb begin
        wr_status  = wr_en && (addr == OFS_STATUS);
        wr_control = wr_en && (addr == OFS_CONTROL);
    end

    assign unused_wd_bits = ^{wr_data[31:14], wr_data[9:6], wr_data[4:1]};

    pm_timer #(.TMR_W(TMR_W), .OVF_BIT(OVF_BIT)) u_timer (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en),
        .count(tmr_count), .ovf_pulse(tmr_ovf)
    );

    pm_status u_status (
        .clk(clk), .rst_n(rst_n),
        .ovf_set(tmr_ovf), .gbl_set(fw_release),
        .clr_wr(wr_status),
        .clr_tmrof(wr_data[ST_TMROF]), .clr_gbl(wr_data[ST_GBL]),
        .tmrof(st_tmrof), .gbl(st_gbl)
    );

    pm_control u_control (
        .clk(clk), .rst_n(rst_n), .rtc_rst_n(rtc_rst_n),
        .ctl_wr(wr_control),
        .wd_sci(wr_data[CT_SCI]), .wd_scr(wr_data[CT_SCR]),
        .wd_rel(wr_data[CT_REL]), .wd_sleep(wr_data[CT_SLEEP]),
        .wd_typ(wr_data[CT_TYPLO+2:CT_TYPLO]),
        .sci_en(c_sci), .scratch(c_scr), .slp_typ(c_typ),
        .fw_event(fw_event), .sleep_req(sleep_req), .sleep_type(sleep_type)
    );

    // Interrupt request: gated timer overflow or unconditional global status
    always_comb sci_req = (st_tmrof && tmr_ovf_en && c_sci) || st_gbl;

    // Read mux; trigger and reserved bits return zero
    always_comb begin
        rd_data = '0;
        if (rd_en) begin
            unique case (addr)
                OFS_STATUS: begin
                    rd_data[ST_TMROF] = st_tmrof;
                    rd_data[ST_GBL]   = st_gbl;
                end
                OFS_CONTROL: begin
                    rd_data[CT_SCI]                = c_sci;
                    rd_data[CT_SCR]                = c_scr;
                    rd_data[CT_TYPLO+2:CT_TYPLO]   = c_typ;
                end
                OFS_TIMER: rd_data = {{PAD_W{1'b0}}, tmr_count};
                default:   rd_data = '0;
            endcase
        end
    end

    // R6
    gbl_forces_sci_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_gbl |-> sci_req);
endmodule

// File: tb/pm1_evt_regs_test.sv
// Bench: behavioural reference model updated on every rising edge and compared
// on every falling edge, plus directed scenarios for each requirement.
module pm1_evt_regs_test;
    localparam int TW = 8;
    localparam int OB = 6;
    localparam int TMOD = 256;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0, rtc_rst_n = 1'b0;
    logic        tick_en = 1'b0, tmr_ovf_en = 1'b0, fw_release = 1'b0;
    logic [3:0]  addr = 4'h0;
    logic        wr_en = 1'b0, rd_en = 1'b0;
    logic [31:0] wr_data = 32'h0;
    logic [31:0] rd_data;
    logic        sci_req, fw_event, sleep_req;
    logic [2:0]  sleep_type;

    int tests = 0, fails = 0;
    bit mon_on = 0;

    // reference state
    int m_tmr = 0;
    bit m_tmrof = 0, m_gbl = 0, m_sci = 0, m_scr = 0, m_fw = 0, m_sreq = 0;
    int m_typ = 0, m_styp = 0;

    always #2.5 clk = ~clk;

    pm1_evt_regs #(.TMR_W(TW), .OVF_BIT(OB)) uut (
        .clk(clk), .rst_n(rst_n), .rtc_rst_n(rtc_rst_n), .tick_en(tick_en),
        .tmr_ovf_en(tmr_ovf_en), .fw_release(fw_release), .addr(addr),
        .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en), .rd_data(rd_data),
        .sci_req(sci_req), .fw_event(fw_event), .sleep_req(sleep_req),
        .sleep_type(sleep_type)
    );

    task automatic chk(input string tag, input longint act, input longint exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: got %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic bit typ_ok(input int t);
        return !(t == 2 || t == 3 || t == 4);
    endfunction

    function automatic longint m_read(input logic [3:0] a);
        case (a)
            4'h0: return (longint'(m_gbl) << 5) | longint'(m_tmrof);
            4'h4: return (longint'(m_typ) << 10) | (longint'(m_scr) << 1) | longint'(m_sci);
            4'h8: return longint'(m_tmr);
            default: return 0;
        endcase
    endfunction

    // Reference model: advance state on every rising edge
    always @(posedge clk) begin
        bit ws, wc, fall;
        int nt, t;
        ws = wr_en && addr == 4'h0;
        wc = wr_en && addr == 4'h4;
        t  = int'(wr_data[12:10]);
        if (!rtc_rst_n) m_typ = 0; else if (wc) m_typ = t;
        if (!rst_n) begin
            m_tmr = 0; m_tmrof = 0; m_gbl = 0; m_sci = 0; m_scr = 0;
            m_fw = 0; m_sreq = 0; m_styp = 0;
        end else begin
            fall = 0;
            if (tick_en) begin
                nt = (m_tmr + 1) % TMOD;
                fall = ((m_tmr >> OB) & 1) == 1 && ((nt >> OB) & 1) == 0;
                m_tmr = nt;
            end
            if (ws && wr_data[0]) m_tmrof = 0;
            if (fall) m_tmrof = 1;
            if (ws && wr_data[5]) m_gbl = 0;
            if (fw_release) m_gbl = 1;
            m_fw   = wc && wr_data[2];
            m_sreq = wc && wr_data[13] && typ_ok(t);
            if (m_sreq) m_styp = t;
            if (wc) begin m_sci = wr_data[0]; m_scr = wr_data[1]; end
        end
        mon_on = 1;
    end

    // Per-cycle comparison of every output against the model
    always @(negedge clk) begin
        if (mon_on) begin
            chk("R7 sci_req", sci_req, (m_tmrof && tmr_ovf_en && m_sci) || m_gbl);
            chk("R9 fw_event", fw_event, m_fw);
            chk("R10 sleep_req", sleep_req, m_sreq);
            chk("R10 sleep_type", sleep_type, m_styp);
            if (rd_en) chk("R8 rd_data", rd_data, m_read(addr));
        end
    end

    task automatic step();
        @(posedge clk); #1;
        wr_en = 0; rd_en = 0; fw_release = 0; tick_en = 0;
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        wr_en = 1; addr = a; wr_data = d; step();
    endtask

    task automatic expect_rd(input logic [3:0] a, input longint exp, input string tag);
        rd_en = 1; addr = a; #1;
        chk(tag, rd_data, exp);
        step();
    endtask

    task automatic report();
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    endtask

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        report();
    end

    initial begin
        repeat (3) step();
        rst_n = 1; rtc_rst_n = 1;
        step();
        // R1 reset state
        expect_rd(4'h0, 0, "R1 status");
        expect_rd(4'h4, 0, "R1 control");
        expect_rd(4'h8, 0, "R1 timer");
        chk("R1 sci_req", sci_req, 0);
        chk("R1 sleep_req", sleep_req, 0);

        // R2 / R3 timer and overflow edge
        repeat (127) begin tick_en = 1; step(); end
        expect_rd(4'h8, 8'h7F, "R2 timer count");
        expect_rd(4'h0, 0, "R3 no overflow before edge");
        tick_en = 1; step();
        expect_rd(4'h0, 1, "R3 overflow on falling edge");
        expect_rd(4'h8, 8'h80, "R2 timer count after edge");

        // R7 gating by enables
        tmr_ovf_en = 1; step();
        chk("R7 sci off without enable", sci_req, 0);
        wr(4'h4, 32'h1);
        chk("R7 sci on with enables", sci_req, 1);
        tmr_ovf_en = 0; step();
        chk("R7 sci off with ovf enable low", sci_req, 0);

        // R4 write-one-to-clear
        wr(4'h0, 32'h0);
        expect_rd(4'h0, 1, "R4 write zero keeps bit");
        wr(4'h0, 32'h1);
        expect_rd(4'h0, 0, "R4 write one clears bit");

        // R2 wrap and R5 set wins over clear
        while (m_tmr != TMOD - 1) begin tick_en = 1; step(); end
        wr(4'h0, 32'h0);
        fw_release = 1; step();
        expect_rd(4'h0, 32'h20, "R6 global status set");
        tick_en = 1; fw_release = 1; wr(4'h0, 32'h21);
        expect_rd(4'h0, 32'h21, "R5 set wins over clear");
        expect_rd(4'h8, 0, "R2 timer wrapped");

        // R6 global status forces interrupt with enable off
        wr(4'h4, 32'h0);
        wr(4'h0, 32'h1);
        chk("R6 sci with enable off", sci_req, 1);
        wr(4'h0, 32'h20);
        chk("R6 sci drops after clear", sci_req, 0);

        // R9 release trigger
        wr(4'h4, 32'h4);
        chk("R9 fw_event pulse", fw_event, 1);
        step();
        chk("R9 fw_event one cycle", fw_event, 0);
        expect_rd(4'h4, 0, "R9 release reads zero");

        // R10 valid sleep types
        foreach (m_read_types[i]) begin
            wr(4'h4, (32'(m_read_types[i]) << 10) | 32'h2000);
            chk("R10 sleep_req pulse", sleep_req, 1);
            chk("R10 sleep_type value", sleep_type, m_read_types[i]);
            step();
            chk("R10 sleep_req one cycle", sleep_req, 0);
        end
        expect_rd(4'h4, 32'h1C00, "R10 sleep enable reads zero");

        // R11 reserved types dropped
        for (int t = 2; t <= 4; t++) begin
            wr(4'h4, (32'(t) << 10) | 32'h2000);
            chk("R11 no pulse on reserved type", sleep_req, 0);
            chk("R11 sleep_type unchanged", sleep_type, 7);
        end

        // R8 layout and reserved bits
        wr(4'h4, 32'hFFFF_DFFF);
        expect_rd(4'h4, 32'h1C03, "R8 control layout");
        fw_release = 1; step();
        while (m_tmrof == 0) begin tick_en = 1; step(); end
        expect_rd(4'h0, 32'h21, "R8 status layout");
        expect_rd(4'hC, 0, "R8 unmapped offset");

        // R12 sleep type reset domains
        wr(4'h4, 32'h1800);
        rst_n = 0; step(); step();
        rst_n = 1; step();
        expect_rd(4'h4, 32'h1800, "R12 type kept through platform reset");
        rtc_rst_n = 0; step();
        rtc_rst_n = 1; step();
        expect_rd(4'h4, 0, "R12 type cleared by rtc reset");

        repeat (2) step();
        report();
    end

    int m_read_types[5] = '{0, 1, 5, 6, 7};
endmodule